// File: doc/BRIEF.md
# Flash Operation Status Poller

This block finishes the job after a program, erase or buffered-write command has been sent to a parallel NOR flash device. It repeatedly reads a status word from one fixed address through a separate bus cycle engine. From each word it decodes the data-polling bit (bit 7), the toggle bit (bit 6), the internal time-limit bit (bit 5) and the buffer-abort bit (bit 1). It also samples the device's ready line. When the outcome is known it reports a 2-bit result to the host.

The host pulses `start` with the kind of operation, the address to poll, the bit 7 value that was written and a poll budget. For a buffered write, the poll address must be the last location loaded into the buffer. `busy` stays high until a result is known. The result then stays on `result` until the next accepted start.

Operation codes on `op_kind`: 0 = program, 1 = erase, 2 = buffered write, 3 = handled as program. Result codes: 0 = pending, 1 = done, 2 = timeout, 3 = abort.

States: `S_IDLE` (waiting for start), `S_PRIME` (first read, records bit 6 only), `S_POLL` (regular reads), `S_CONFIRM` (confirming read after an abort flag), `S_RECHK_A` and `S_RECHK_B` (the two reads after a time-limit flag). Transitions:
- Start: `S_IDLE`→`S_PRIME`.
- Primed: `S_PRIME`→`S_POLL`.
- Budget spent on the first read: `S_PRIME`→`S_IDLE`.
- Resolved: `S_POLL`→`S_IDLE`, on done or watchdog.
- Abort seen: `S_POLL`→`S_CONFIRM`.
- Limit seen: `S_POLL`→`S_RECHK_A`.
- Abort cleared: `S_CONFIRM`→`S_POLL`.
- Abort confirmed: `S_CONFIRM`→`S_IDLE`.
- Recheck: `S_RECHK_A`→`S_RECHK_B`→`S_IDLE`.

Top module: `flash_status_poller`

## Requirements
- R1: A `start` pulse seen while `busy` is low is accepted: `busy` is 1 in the next cycle and `result` reads 0 (pending) for as long as `busy` stays high.
- R2: Every read request carries the `poll_addr` latched at the accepted start. A `start` pulse and any input change while `busy` is high are ignored.
- R3: At most one read is outstanding. `rd_req` is a one-cycle pulse, and no new request is made until `rd_ack` returns the data of the previous one.
- R4: The first read after a start only records bit 6 as the toggle reference. Its data cannot finish the poll, so any result other than timeout needs at least two reads.
- R5: A regular read means completion when both hold:
  - For program or buffered write, bit 7 equals `expect_bit7`. For erase, bit 6 equals bit 6 of the previous read.
  - `ready_line` is 1 with that read.
  
  Completion ends the poll with result 1. Completion has priority over R6, R7 and R8.
- R6: For buffered write only, a regular read that is not complete and has bit 1 = 1 causes one confirming read. If bit 1 is still 1 there, the result is 3. Otherwise regular polling resumes. Bit 1 has no effect for program or erase.
- R7: A regular read that is neither complete nor sent to R6 and has bit 5 = 1 causes exactly two further reads. The result is 1 if bit 6 is equal in those two reads, and 2 otherwise.
- R8: Only the first read and regular reads count toward the watchdog; confirming reads and recheck reads do not. When the count reaches `max_polls` on a read that led to no other outcome, the result is 2. A `max_polls` of 0 acts as 1.
- R9: While `busy` is low, `result` keeps its value until the next accepted start.
- R10: Bits 4, 3, 2 and 0 of `rd_data` have no effect on any outcome or on the number of reads.
- R11: After reset, `busy`, `rd_req` and `result` are all 0, and a read is requested only while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a poll (one-cycle pulse) |
| op_kind | input | 2 | 0 program, 1 erase, 2 buffered write |
| poll_addr | input | AW | Address to poll |
| expect_bit7 | input | 1 | Bit 7 of the data being written |
| max_polls | input | CW | Watchdog budget in counted reads |
| busy | output | 1 | Poll in progress |
| result | output | 2 | 0 pending, 1 done, 2 timeout, 3 abort |
| rd_req | output | 1 | Read request pulse to the bus cycle engine |
| rd_addr | output | AW | Address of the requested read |
| rd_ack | input | 1 | Read data valid |
| rd_data | input | DW | Status word returned by the read |
| ready_line | input | 1 | Device ready line, 1 = idle |

## Verification
The hardest outcomes to reach from the ports are the two conditional ones:
- the time-limit recheck that ends in done because the device finishes between the two extra reads;
- a buffered-write abort flag that clears on the confirming read.

The bench drives a scripted device model in which the busy length, the read where bit 5 first rises, and the read where bit 1 rises are swept against each other. Bit 1 can rise either sticky or for a single read. The ready-line lag and the read latency are also varied, which places every priority crossing inside the sweep. For each combination, the expected result and the exact read count come from a step-by-step model of the requirements.

// File: rtl/fsp_pkg.sv
package fsp_pkg;

    typedef enum logic [1:0] {
        OP_PROG  = 2'd0,
        OP_ERASE = 2'd1,
        OP_WBUF  = 2'd2
    } op_e;

    typedef enum logic [1:0] {
        RES_PEND    = 2'd0,
        RES_DONE    = 2'd1,
        RES_TIMEOUT = 2'd2,
        RES_ABORT   = 2'd3
    } res_e;

    typedef enum logic [2:0] {
        S_IDLE    = 3'd0,
        S_PRIME   = 3'd1,
        S_POLL    = 3'd2,
        S_CONFIRM = 3'd3,
        S_RECHK_A = 3'd4,
        S_RECHK_B = 3'd5
    } state_e;

    // Status word bit positions decoded from the device
    localparam int BIT_POLL   = 7;
    localparam int BIT_TOGGLE = 6;
    localparam int BIT_LIMIT  = 5;
    localparam int BIT_ABORT  = 1;

endpackage

// File: rtl/fsp_status_decode.sv
module fsp_status_decode
    import fsp_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [DW-1:0] data,
    input  logic          prev_tog,
    input  logic [1:0]    op,
    input  logic          exp7,
    output logic          toggled,
    output logic          complete,
    output logic          limit_hit,
    output logic          abort_hit
);

    logic is_erase;
    logic is_wbuf;

    always_comb begin
        is_erase  = (op == OP_ERASE);
        is_wbuf   = (op == OP_WBUF);
        toggled   = data[BIT_TOGGLE] ^ prev_tog;
        complete  = is_erase ? !toggled : (data[BIT_POLL] == exp7);
        limit_hit = data[BIT_LIMIT];
        abort_hit = is_wbuf && data[BIT_ABORT];
    end

endmodule

// File: rtl/fsp_toggle_track.sv
module fsp_toggle_track (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic bit_in,
    output logic prev
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev <= 1'b0;
        end else if (load) begin
            prev <= bit_in;
        end
    end

endmodule

// File: rtl/fsp_poll_counter.sv
module fsp_poll_counter #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          inc,
    input  logic [CW-1:0] limit,
    output logic          last
);

    localparam int XW = CW + 1;

    logic [CW-1:0] cnt;
    logic [XW-1:0] next_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear) begin
            cnt <= '0;
        end else if (inc && (cnt != {CW{1'b1}})) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Asserted when the read now completing is the budgeted one
    always_comb begin
        next_cnt = {1'b0, cnt} + XW'(1);
        last     = (next_cnt >= {1'b0, limit});
    end

endmodule

// File: rtl/fsp_read_issuer.sv
module fsp_read_issuer (
    input  logic clk,
    input  logic rst_n,
    input  logic want,
    input  logic ack,
    output logic req,
    output logic taken
);

    logic pend;

    always_comb begin
        req   = want && !pend;
        taken = ack && pend;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend <= 1'b0;
        end else if (taken) begin
            pend <= 1'b0;
        end else if (req) begin
            pend <= 1'b1;
        end
    end

endmodule

// File: rtl/flash_status_poller.sv
module flash_status_poller
    import fsp_pkg::*;
#(
    parameter int AW = 24,
    parameter int DW = 8,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [1:0]    op_kind,
    input  logic [AW-1:0] poll_addr,
    input  logic          expect_bit7,
    input  logic [CW-1:0] max_polls,
    output logic          busy,
    output logic [1:0]    result,
    output logic          rd_req,
    output logic [AW-1:0] rd_addr,
    input  logic          rd_ack,
    input  logic [DW-1:0] rd_data,
    input  logic          ready_line
);

    state_e        state;
    state_e        nxt;
    logic [1:0]    op_q;
    logic [AW-1:0] addr_q;
    logic          exp_q;
    logic [CW-1:0] max_q;
    logic [1:0]    res_q;

    logic accept;
    logic want;
    logic taken;
    logic prev_tog;
    logic toggled;
    logic complete;
    logic limit_hit;
    logic abort_hit;
    logic last;
    logic count_rd;
    logic fin;
    res_e fin_code;

    // ---------------- sub-blocks ----------------
    fsp_read_issuer u_issue (
        .clk   (clk),
        .rst_n (rst_n),
        .want  (want),
        .ack   (rd_ack),
        .req   (rd_req),
        .taken (taken)
    );

    fsp_status_decode #(.DW(DW)) u_dec (
        .data      (rd_data),
        .prev_tog  (prev_tog),
        .op        (op_q),
        .exp7      (exp_q),
        .toggled   (toggled),
        .complete  (complete),
        .limit_hit (limit_hit),
        .abort_hit (abort_hit)
    );

    fsp_toggle_track u_tog (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (taken),
        .bit_in (rd_data[BIT_TOGGLE]),
        .prev   (prev_tog)
    );

    fsp_poll_counter #(.CW(CW)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (accept),
        .inc   (count_rd),
        .limit (max_q),
        .last  (last)
    );

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // ---------------- next state ----------------
    always_comb begin
        nxt      = state;
        fin      = 1'b0;
        fin_code = RES_PEND;
        unique case (state)
            S_IDLE: begin
                if (start) begin
                    nxt = S_PRIME;
                end
            end
            S_PRIME: begin
                if (taken) begin
                    if (last) begin
                        fin      = 1'b1;
                        fin_code = RES_TIMEOUT;
                        nxt      = S_IDLE;
                    end else begin
                        nxt = S_POLL;
                    end
                end
            end
            S_POLL: begin
                if (taken) begin
                    if (complete && ready_line) begin
                        fin      = 1'b1;
                        fin_code = RES_DONE;
                        nxt      = S_IDLE;
                    end else if (abort_hit) begin
                        nxt = S_CONFIRM;
                    end else if (limit_hit) begin
                        nxt = S_RECHK_A;
                    end else if (last) begin
                        fin      = 1'b1;
                        fin_code = RES_TIMEOUT;
                        nxt      = S_IDLE;
                    end
                end
            end
            S_CONFIRM: begin
                if (taken) begin
                    if (abort_hit) begin
                        fin      = 1'b1;
                        fin_code = RES_ABORT;
                        nxt      = S_IDLE;
                    end else begin
                        nxt = S_POLL;
                    end
                end
            end
            S_RECHK_A: begin
                if (taken) begin
                    nxt = S_RECHK_B;
                end
            end
            S_RECHK_B: begin
                if (taken) begin
                    fin      = 1'b1;
                    fin_code = toggled ? RES_TIMEOUT : RES_DONE;
                    nxt      = S_IDLE;
                end
            end
            default: begin
                nxt = S_IDLE;
            end
        endcase
    end

    // ---------------- outputs ----------------
    always_comb begin
        accept   = (state == S_IDLE) && start;
        want     = (state != S_IDLE);
        count_rd = taken && ((state == S_PRIME) || (state == S_POLL));
        busy     = (state != S_IDLE);
        result   = res_q;
        rd_addr  = addr_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q  <= RES_PEND;
            op_q   <= 2'd0;
            addr_q <= '0;
            exp_q  <= 1'b0;
            max_q  <= '0;
        end else if (accept) begin
            res_q  <= RES_PEND;
            op_q   <= op_kind;
            addr_q <= poll_addr;
            exp_q  <= expect_bit7;
            max_q  <= max_polls;
        end else if (fin) begin
            res_q <= fin_code;
        end
    end

endmodule

// File: rtl/fsp_checker.sv
module fsp_checker #(
    parameter int AW = 24
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic [1:0]    op_kind,
    input logic          busy,
    input logic [1:0]    result,
    input logic          rd_req,
    input logic          rd_ack,
    input logic [AW-1:0] rd_addr
);

    logic       pend_c;
    logic [1:0] acks_c;
    logic [1:0] op_c;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_c <= 1'b0;
            acks_c <= 2'd0;
            op_c   <= 2'd0;
        end else begin
            if (rd_req) begin
                pend_c <= 1'b1;
            end else if (rd_ack) begin
                pend_c <= 1'b0;
            end
            if (start && !busy) begin
                acks_c <= 2'd0;
                op_c   <= op_kind;
            end else if (rd_ack && pend_c && (acks_c != 2'd3)) begin
                acks_c <= acks_c + 2'd1;
            end
        end
    end

    p_start_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy |=> busy && (result == 2'd0));

    p_addr_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) |-> $stable(rd_addr));

    p_req_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> !rd_req);

    p_single_outstanding_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> !pend_c);

    p_two_reads_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) && (result != 2'd2) |-> (acks_c >= 2'd2));

    p_abort_wbuf_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) && (result == 2'd3) |-> (op_c == 2'd2));

    p_result_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && !start |=> $stable(result));

    p_req_in_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> busy);

endmodule

bind flash_status_poller fsp_checker #(.AW(AW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .op_kind (op_kind),
    .busy    (busy),
    .result  (result),
    .rd_req  (rd_req),
    .rd_ack  (rd_ack),
    .rd_addr (rd_addr)
);

// File: tb/tb_flash_status_poller.sv
module tb_flash_status_poller;

    localparam int AW = 24;
    localparam int DW = 8;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [1:0]    op_kind = 2'd0;
    logic [AW-1:0] poll_addr = '0;
    logic          expect_bit7 = 1'b0;
    logic [CW-1:0] max_polls = '0;
    logic          busy;
    logic [1:0]    result;
    logic          rd_req;
    logic [AW-1:0] rd_addr;
    logic          rd_ack = 1'b0;
    logic [DW-1:0] rd_data = '0;
    logic          ready_line = 1'b0;

    int n_chk = 0;
    int n_bad = 0;

    // scenario knobs of the device model
    int   g_op, g_b, g_t5, g_ta, g_rlag, g_mp, g_lat;
    logic g_exp, g_sticky;
    logic [AW-1:0] cur_addr;

    int lat_cnt = 0, ridx = 0, nreq = 0, addr_bad = 0, ovl = 0;

    always #10 clk = ~clk;

    flash_status_poller #(.AW(AW), .DW(DW), .CW(CW)) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .op_kind     (op_kind),
        .poll_addr   (poll_addr),
        .expect_bit7 (expect_bit7),
        .max_polls   (max_polls),
        .busy        (busy),
        .result      (result),
        .rd_req      (rd_req),
        .rd_addr     (rd_addr),
        .rd_ack      (rd_ack),
        .rd_data     (rd_data),
        .ready_line  (ready_line)
    );

    // status word of read number i; noise on bits 4,3,2,0 (R10)
    function automatic logic [7:0] stat(input int i);
        logic [7:0] v;
        v = 8'((i * 37) + (g_b * 5)) & 8'h1D;
        if (i < g_b) begin
            v[7] = ~g_exp;
            v[6] = ((i % 2) == 1);
            v[5] = (g_t5 >= 0) && (i >= g_t5);
            v[1] = (g_ta >= 0) && (g_sticky ? (i >= g_ta) : (i == g_ta));
        end else begin
            v[7] = g_exp;
            v[6] = ((g_b % 2) == 1);
        end
        return v;
    endfunction

    function automatic logic rdy_at(input int i);
        return (i >= g_b + g_rlag);
    endfunction

    // step model of R4..R8
    function automatic void ref_run(output int res, output int nr);
        logic [7:0] s;
        logic [7:0] s2;
        logic       p;
        logic       comp;
        int         i;
        int         cnt;
        s   = stat(0);
        p   = s[6];
        i   = 1;
        cnt = 1;
        res = 2;
        nr  = 1;
        if (cnt >= g_mp) return;
        for (int k = 0; k < 200; k++) begin
            s   = stat(i);
            comp = (g_op == 1) ? (s[6] == p) : (s[7] == g_exp);
            p   = s[6];
            if (comp && rdy_at(i)) begin
                i++;
                res = 1; nr = i; return;
            end
            i++;
            cnt++;
            if ((g_op == 2) && s[1]) begin
                s = stat(i); i++; p = s[6];
                if (s[1]) begin res = 3; nr = i; return; end
                continue;
            end
            if (s[5]) begin
                s  = stat(i); i++;
                s2 = stat(i); i++;
                res = (s2[6] != s[6]) ? 2 : 1;
                nr  = i;
                return;
            end
            if (cnt >= g_mp) begin res = 2; nr = i; return; end
        end
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // device and bus-engine model
    always @(negedge clk) begin
        rd_ack = 1'b0;
        if (rd_req) begin
            nreq++;
            if (rd_addr != cur_addr) addr_bad++;
            if (lat_cnt != 0) ovl++;
            lat_cnt = g_lat;
        end else if (lat_cnt != 0) begin
            lat_cnt--;
            if (lat_cnt == 0) begin
                rd_ack     = 1'b1;
                rd_data    = stat(ridx);
                ready_line = rdy_at(ridx);
                ridx++;
            end
        end
    end

    task automatic run_one(input int run);
        int exp_res, exp_n, guard;
        ridx = 0; nreq = 0; addr_bad = 0; ovl = 0;
        cur_addr = AW'(run * 4099 + 17);
        ref_run(exp_res, exp_n);
        @(negedge clk);
        op_kind     = 2'(g_op);
        poll_addr   = cur_addr;
        expect_bit7 = g_exp;
        max_polls   = CW'(g_mp);
        start       = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R1 busy after start", int'(busy), 1);
        chk("R1 pending code", int'(result), 0);
        if ((run % 7) == 0) begin
            @(negedge clk);
            poll_addr = ~cur_addr;
            op_kind   = 2'd1;
            max_polls = '0;
            start     = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        guard = 0;
        while (busy && guard < 3000) begin
            @(negedge clk);
            guard++;
        end
        chk("R5 R6 R7 R8 R10 result", int'(result), exp_res);
        chk("R4 R6 R7 R8 read count", nreq, exp_n);
        chk("R2 address", addr_bad, 0);
        chk("R3 overlap", ovl, 0);
        poll_addr   = ~poll_addr;
        op_kind     = 2'd3;
        expect_bit7 = ~expect_bit7;
        repeat (3) @(negedge clk);
        chk("R9 result held", int'(result), exp_res);
        chk("R11 no request when idle", nreq, exp_n);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int run;
        repeat (4) @(negedge clk);
        chk("R11 reset busy", int'(busy), 0);
        chk("R11 reset result", int'(result), 0);
        chk("R11 reset request", int'(rd_req), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 idle after reset", int'(busy), 0);
        run = 0;
        for (int op = 0; op < 3; op++) begin
            for (int b = 0; b < 6; b++) begin
                for (int t5 = 0; t5 < 3; t5++) begin
                    for (int ta = 0; ta < 3; ta++) begin
                        for (int rl = 0; rl < 2; rl++) begin
                            for (int mp = 0; mp < 2; mp++) begin
                                g_op     = op;
                                g_b      = b;
                                g_t5     = (t5 == 0) ? -1 : ((t5 == 1) ? 1 : 3);
                                g_ta     = (ta == 0) ? -1 : 2;
                                g_sticky = (ta == 1);
                                g_rlag   = rl;
                                g_mp     = (mp == 0) ? 3 : 8;
                                g_exp    = ((run % 2) == 1);
                                g_lat    = 1 + (run % 3);
                                run_one(run);
                                run++;
                            end
                        end
                    end
                end
            end
        end
        // budget of 0 and 1: first read ends the poll (R8, R4)
        for (int m = 0; m < 2; m++) begin
            g_op = 0; g_b = 4; g_t5 = -1; g_ta = -1; g_sticky = 1'b0;
            g_rlag = 0; g_mp = m; g_exp = 1'b1; g_lat = 2;
            run_one(run + 1 + m);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule